// File: doc/BRIEF.md
# Lifetime-Aware Urgent Frame Picker

This block holds a table of pending transmit-frame descriptors in on-chip RAM and keeps one of them on its output as the most urgent frame to send next. Each descriptor carries a frame pointer, a priority class (0 to 3, where 3 is the most urgent) and a residual lifetime. A free-running divider raises an aging tick every `TICK_CYCLES` clocks (500 clocks, or 10 us at 50 MHz, by default). Each tick starts one sequential pass over the table. The pass lowers every valid lifetime by one and raises the class of entries whose lifetime has fallen below the threshold set for their class. It discards entries whose lifetime reaches zero and counts them. In the same pass it elects the best remaining entry.

Software works with the table through a semaphore. It raises `sw_req` and waits for `sw_gnt`. It then issues exactly one operation, either inserting a descriptor or taking the currently elected frame, and drops `sw_req` to release. Any change to the table starts a fresh election pass once the grant is released. When no election pass is pending, the elected pointer, class and lifetime stay stable on registered outputs.

Top module: `urgent_frame_picker`

## Requirements
- R1: After reset and table clearing, `empty`=1, `full`=0, `sel_valid`=0, `drop_cnt`=0 and `sw_gnt`=0.
- R2: An insert stores pointer, class and lifetime in the lowest free slot; with one entry present, the outputs show exactly that descriptor.
- R3: The election prefers the numerically highest class (3 beats 2 beats 1 beats 0) regardless of lifetime.
- R4: Among entries of the best class, the one with the smallest residual lifetime is elected.
- R5: When class and lifetime are equal, the entry in the lowest slot index wins.
- R6: A take removes the elected entry, and the next election shows the next most urgent entry.
- R7: `full` is 1 when all `DEPTH` slots are valid. An insert in that state changes neither the table nor the outputs.
- R8: Once per `TICK_CYCLES`, every valid lifetime decreases by exactly one.
- R9: After a decrement, an entry of class c<3 whose new lifetime is nonzero and below `promo_thr[c]` moves to class c+1. Class 3 entries never change class.
- R10: An entry whose lifetime reaches zero on a tick is invalidated, and `drop_cnt` increases by one for each such entry.
- R11: `sw_gnt` rises only while `sw_req` is held and falls the cycle after `sw_req` drops. Operations without a grant, and any operation after the first within one grant, are ignored.
- R12: `empty` is 1 with no valid entries, and `sel_valid` is then 0. A take on an empty table has no effect.
- R13: A tick that arrives during an election pass is held pending, and its aging pass runs right after that pass ends. Every entry is therefore aged exactly once per tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_req | input | 1 | Software claims the semaphore while high |
| sw_gnt | output | 1 | Semaphore granted; one operation may be issued |
| ins_en | input | 1 | Insert request (wins over take if both high) |
| ins_ptr | input | 32 | Frame pointer to insert |
| ins_cls | input | 2 | Priority class to insert (3 = most urgent) |
| ins_life | input | 16 | Initial residual lifetime in ticks |
| take_en | input | 1 | Take (remove) the elected frame |
| promo_thr | input | 3x16 | Promotion threshold per class 0..2, element c for class c |
| sel_valid | output | 1 | Elected descriptor is valid |
| sel_ptr | output | 32 | Elected frame pointer |
| sel_cls | output | 2 | Class of elected frame |
| sel_life | output | 16 | Residual lifetime of elected frame |
| full | output | 1 | All slots hold valid entries |
| empty | output | 1 | No valid entries |
| drop_cnt | output | DROP_W | Count of frames discarded on expiry |

## Verification
The assertions check the semaphore timing on every cycle. They also check that the valid count never exceeds the table depth, that the drop counter never moves by more than one per cycle, and that a tick seen during a pass is kept pending and starts an aging pass at the next idle cycle. Only the bench scenarios can show the election order, promotion through several classes, expiry of a promoted frame, rejection of inserts into a full table, and correct single aging of an entry inserted just before a tick. The bench compares these against a behavioural table model.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  localparam int PTR_W  = 32;
  localparam int LIFE_W = 16;
  localparam int CLS_W  = 2;
  localparam int WORD_W = 64;
  localparam int NCLS   = 1 << CLS_W;
  localparam int RSV_W  = WORD_W - PTR_W - LIFE_W - CLS_W - 1;

  typedef struct packed {
    logic [RSV_W-1:0]  rsv;
    logic              vld;
    logic [CLS_W-1:0]  cls;
    logic [LIFE_W-1:0] life;
    logic [PTR_W-1:0]  ptr;
  } desc_t;

  typedef enum logic [1:0] {ST_INIT, ST_IDLE, ST_SCAN, ST_GNT} fsel_st_t;
endpackage

// File: rtl/fsel_tick.sv
module fsel_tick #(
  parameter int PERIOD = 500
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = $clog2(PERIOD);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == CW'(PERIOD - 1));
      cnt  <= (cnt == CW'(PERIOD - 1)) ? '0 : cnt + CW'(1);
    end
  end

  assert_tick_single_R8: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/fsel_ram.sv
module fsel_ram #(
  parameter int DEPTH = 256,
  parameter int W     = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/fsel_age.sv
module fsel_age import fsel_pkg::*; (
  input  logic                         en,
  input  desc_t                        din,
  input  logic [NCLS-2:0][LIFE_W-1:0]  thr,
  output desc_t                        dout,
  output logic                         drop
);
  logic [LIFE_W-1:0] nl;
  logic [LIFE_W-1:0] lim;

  always_comb begin
    lim = '0;
    for (int c = 0; c < NCLS - 1; c++)
      if (din.cls == CLS_W'(c)) lim = thr[c];
  end

  always_comb begin
    dout = din;
    drop = 1'b0;
    nl   = (din.life == '0) ? '0 : din.life - LIFE_W'(1);
    if (en && din.vld) begin
      dout.life = nl;
      if (nl == '0) begin
        dout.vld = 1'b0;
        drop     = 1'b1;
      end else if (din.cls != CLS_W'(NCLS - 1) && nl < lim) begin
        dout.cls = din.cls + CLS_W'(1);
      end
    end
  end
endmodule

// File: rtl/fsel_better.sv
module fsel_better import fsel_pkg::*; (
  input  logic              cand_vld,
  input  logic [CLS_W-1:0]  cand_cls,
  input  logic [LIFE_W-1:0] cand_life,
  input  logic              best_vld,
  input  logic [CLS_W-1:0]  best_cls,
  input  logic [LIFE_W-1:0] best_life,
  output logic              win
);
  always_comb
    win = cand_vld && (!best_vld || cand_cls > best_cls ||
                       (cand_cls == best_cls && cand_life < best_life));
endmodule

// File: rtl/urgent_frame_picker.sv
module urgent_frame_picker import fsel_pkg::*; #(
  parameter int DEPTH       = 256,
  parameter int TICK_CYCLES = 500,
  parameter int DROP_W      = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        sw_req,
  output logic                        sw_gnt,
  input  logic                        ins_en,
  input  logic [PTR_W-1:0]            ins_ptr,
  input  logic [CLS_W-1:0]            ins_cls,
  input  logic [LIFE_W-1:0]           ins_life,
  input  logic                        take_en,
  input  logic [NCLS-2:0][LIFE_W-1:0] promo_thr,
  output logic                        sel_valid,
  output logic [PTR_W-1:0]            sel_ptr,
  output logic [CLS_W-1:0]            sel_cls,
  output logic [LIFE_W-1:0]           sel_life,
  output logic                        full,
  output logic                        empty,
  output logic [DROP_W-1:0]           drop_cnt
);
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int IDX_W  = ADDR_W + 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  fsel_st_t           st;
  logic [IDX_W-1:0]   idx;
  logic               pv;
  logic [ADDR_W-1:0]  pidx;
  logic               age_mode, tick_pend, dirty, op_done;
  logic [CNT_W-1:0]   count;
  logic               best_vld;
  logic [PTR_W-1:0]   best_ptr;
  logic [CLS_W-1:0]   best_cls;
  logic [LIFE_W-1:0]  best_life;
  logic [ADDR_W-1:0]  best_idx;
  logic               free_found;
  logic [ADDR_W-1:0]  free_idx, sel_idx;
  logic               sel_vld_r;
  logic               tick;

  logic               we;
  logic [ADDR_W-1:0]  waddr;
  logic [WORD_W-1:0]  wdata, rdata;
  desc_t              rd_desc, upd, new_desc;
  logic               age_drop, drop_now, win;
  logic               nb_vld;
  logic [PTR_W-1:0]   nb_ptr;
  logic [CLS_W-1:0]   nb_cls;
  logic [LIFE_W-1:0]  nb_life;
  logic [ADDR_W-1:0]  nb_idx;

  fsel_tick #(.PERIOD(TICK_CYCLES)) u_tick (.clk(clk), .rst(rst), .tick(tick));

  fsel_ram #(.DEPTH(DEPTH), .W(WORD_W)) u_ram (
    .clk(clk), .we(we), .waddr(waddr), .wdata(wdata),
    .raddr(idx[ADDR_W-1:0]), .rdata(rdata));

  assign rd_desc = desc_t'(rdata);

  fsel_age u_age (.en(age_mode), .din(rd_desc), .thr(promo_thr),
                  .dout(upd), .drop(age_drop));

  fsel_better u_better (
    .cand_vld(pv && upd.vld), .cand_cls(upd.cls), .cand_life(upd.life),
    .best_vld(best_vld), .best_cls(best_cls), .best_life(best_life), .win(win));

  assign drop_now  = pv && age_drop;
  assign full      = (count == CNT_W'(DEPTH));
  assign empty     = (count == '0);
  assign sel_valid = sel_vld_r && !empty;

  always_comb begin
    new_desc      = '0;
    new_desc.vld  = 1'b1;
    new_desc.cls  = ins_cls;
    new_desc.life = ins_life;
    new_desc.ptr  = ins_ptr;
  end

  always_comb begin
    nb_vld  = best_vld;
    nb_ptr  = best_ptr;
    nb_cls  = best_cls;
    nb_life = best_life;
    nb_idx  = best_idx;
    if (win) begin
      nb_vld  = 1'b1;
      nb_ptr  = upd.ptr;
      nb_cls  = upd.cls;
      nb_life = upd.life;
      nb_idx  = pidx;
    end
  end

  // single write port shared by clearing, aging and software operations
  always_comb begin
    we    = 1'b0;
    waddr = pidx;
    wdata = upd;
    case (st)
      ST_INIT: begin
        we    = 1'b1;
        waddr = idx[ADDR_W-1:0];
        wdata = '0;
      end
      ST_SCAN: we = pv && age_mode;
      ST_GNT: begin
        if (sw_req && !op_done) begin
          if (ins_en && !full) begin
            we    = 1'b1;
            waddr = free_idx;
            wdata = new_desc;
          end else if (!ins_en && take_en && sel_valid) begin
            we    = 1'b1;
            waddr = sel_idx;
            wdata = '0;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_INIT;
      idx <= '0;
      pv <= 1'b0;
      pidx <= '0;
      age_mode <= 1'b0;
      tick_pend <= 1'b0;
      dirty <= 1'b0;
      op_done <= 1'b0;
      count <= '0;
      best_vld <= 1'b0;
      best_ptr <= '0;
      best_cls <= '0;
      best_life <= '0;
      best_idx <= '0;
      free_found <= 1'b0;
      free_idx <= '0;
      sel_idx <= '0;
      sel_vld_r <= 1'b0;
      sel_ptr <= '0;
      sel_cls <= '0;
      sel_life <= '0;
      sw_gnt <= 1'b0;
      drop_cnt <= '0;
    end else begin
      case (st)
        ST_INIT: begin
          idx <= idx + IDX_W'(1);
          if (idx == IDX_W'(DEPTH - 1)) begin
            st  <= ST_IDLE;
            idx <= '0;
          end
        end
        ST_IDLE: begin
          if (tick_pend || dirty) begin
            st         <= ST_SCAN;
            age_mode   <= tick_pend;
            idx        <= '0;
            pv         <= 1'b0;
            best_vld   <= 1'b0;
            free_found <= 1'b0;
          end else if (sw_req) begin
            st      <= ST_GNT;
            sw_gnt  <= 1'b1;
            op_done <= 1'b0;
          end
        end
        ST_SCAN: begin
          if (idx < IDX_W'(DEPTH)) begin
            idx  <= idx + IDX_W'(1);
            pv   <= 1'b1;
            pidx <= idx[ADDR_W-1:0];
          end else begin
            pv <= 1'b0;
          end
          if (pv) begin
            best_vld  <= nb_vld;
            best_ptr  <= nb_ptr;
            best_cls  <= nb_cls;
            best_life <= nb_life;
            best_idx  <= nb_idx;
            if (drop_now) begin
              count    <= count - CNT_W'(1);
              drop_cnt <= drop_cnt + DROP_W'(1);
            end
            if (!upd.vld && !free_found) begin
              free_found <= 1'b1;
              free_idx   <= pidx;
            end
            if (pidx == ADDR_W'(DEPTH - 1)) begin
              st        <= ST_IDLE;
              pv        <= 1'b0;
              dirty     <= 1'b0;
              sel_vld_r <= nb_vld;
              sel_ptr   <= nb_ptr;
              sel_cls   <= nb_cls;
              sel_life  <= nb_life;
              sel_idx   <= nb_idx;
            end
          end
        end
        ST_GNT: begin
          if (!sw_req) begin
            st     <= ST_IDLE;
            sw_gnt <= 1'b0;
            dirty  <= op_done;
          end else if (!op_done && (ins_en || take_en)) begin
            op_done <= 1'b1;
            if (ins_en) begin
              if (!full) count <= count + CNT_W'(1);
            end else if (sel_valid) begin
              count     <= count - CNT_W'(1);
              sel_vld_r <= 1'b0;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
      // a tick is remembered until an aging pass starts from idle
      if (tick) tick_pend <= 1'b1;
      else if (st == ST_IDLE && tick_pend) tick_pend <= 1'b0;
    end
  end

  assert_gnt_release_R11: assert property (@(posedge clk) disable iff (rst)
    (sw_gnt && !sw_req) |=> !sw_gnt);
  assert_gnt_needs_req_R11: assert property (@(posedge clk) disable iff (rst)
    (!sw_req && !sw_gnt) |=> !sw_gnt);
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
  assert_drop_step_R10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (drop_cnt == $past(drop_cnt) || drop_cnt == $past(drop_cnt) + DROP_W'(1)));
  assert_tick_held_R13: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SCAN && tick) |=> tick_pend);
  assert_age_start_R13: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && tick_pend) |=> (st == ST_SCAN && age_mode));
endmodule

// File: tb/urgent_frame_picker_tb.sv
module urgent_frame_picker_tb;
  import fsel_pkg::*;
  localparam int D  = 8;
  localparam int TK = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic sw_req = 0, ins_en = 0, take_en = 0;
  logic [PTR_W-1:0] ins_ptr = '0;
  logic [CLS_W-1:0] ins_cls = '0;
  logic [LIFE_W-1:0] ins_life = '0;
  logic [NCLS-2:0][LIFE_W-1:0] thr;
  logic sw_gnt, sel_valid, full, empty;
  logic [PTR_W-1:0] sel_ptr;
  logic [CLS_W-1:0] sel_cls;
  logic [LIFE_W-1:0] sel_life;
  logic [15:0] drop_cnt;

  assign thr = {16'd2, 16'd3, 16'd5};

  urgent_frame_picker #(.DEPTH(D), .TICK_CYCLES(TK), .DROP_W(16)) u_dut (
    .clk(clk), .rst(rst), .sw_req(sw_req), .sw_gnt(sw_gnt), .ins_en(ins_en),
    .ins_ptr(ins_ptr), .ins_cls(ins_cls), .ins_life(ins_life), .take_en(take_en),
    .promo_thr(thr), .sel_valid(sel_valid), .sel_ptr(sel_ptr), .sel_cls(sel_cls),
    .sel_life(sel_life), .full(full), .empty(empty), .drop_cnt(drop_cnt));

  int m_vld[D], m_ptr[D], m_cls[D], m_life[D];
  int m_drop = 0;
  int cyc = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  function automatic int th(int c);
    case (c)
      0: return 5;
      1: return 3;
      default: return 2;
    endcase
  endfunction

  function automatic void model_age();
    for (int i = 0; i < D; i++) begin
      if (m_vld[i] != 0) begin
        m_life[i] = (m_life[i] > 0) ? m_life[i] - 1 : 0;
        if (m_life[i] == 0) begin
          m_vld[i] = 0;
          m_drop++;
        end else if (m_cls[i] < 3 && m_life[i] < th(m_cls[i])) begin
          m_cls[i]++;
        end
      end
    end
  endfunction

  function automatic int elect();
    int b = -1;
    for (int i = 0; i < D; i++)
      if (m_vld[i] != 0)
        if (b < 0 || m_cls[i] > m_cls[b] || (m_cls[i] == m_cls[b] && m_life[i] < m_life[b]))
          b = i;
    return b;
  endfunction

  function automatic int m_count();
    int n = 0;
    for (int i = 0; i < D; i++) if (m_vld[i] != 0) n++;
    return n;
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
    cyc++;
    if (cyc % TK == 0) model_age();
  endtask

  task automatic chk(string tag, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    int b = elect();
    chk(tag, "sel_valid", longint'(sel_valid), (b >= 0) ? 1 : 0);
    if (b >= 0) begin
      chk(tag, "sel_ptr", longint'(sel_ptr), longint'(m_ptr[b]));
      chk(tag, "sel_cls", longint'(sel_cls), longint'(m_cls[b]));
      chk(tag, "sel_life", longint'(sel_life), longint'(m_life[b]));
    end
    chk(tag, "full", longint'(full), (m_count() == D) ? 1 : 0);
    chk(tag, "empty", longint'(empty), (m_count() == 0) ? 1 : 0);
    chk(tag, "drop_cnt", longint'(drop_cnt), longint'(m_drop));
    chk(tag, "sw_gnt", longint'(sw_gnt), 0);
  endtask

  task automatic win(int lo, int hi);
    while ((cyc % TK) < lo || (cyc % TK) > hi) step();
  endtask

  // one semaphore round: claim, one operation (optionally held two cycles), release
  task automatic do_op(int lo, int hi, bit ins, int ptr, int cls, int life, bit twice);
    win(lo, hi);
    sw_req = 1;
    step();
    for (int k = 0; k < 20 && !sw_gnt; k++) step();
    ins_en = ins; take_en = !ins;
    ins_ptr = PTR_W'(ptr); ins_cls = CLS_W'(cls); ins_life = LIFE_W'(life);
    step();
    if (ins) begin
      int s = -1;
      for (int i = D - 1; i >= 0; i--) if (m_vld[i] == 0) s = i;
      if (s >= 0) begin
        m_vld[s] = 1; m_ptr[s] = ptr; m_cls[s] = cls; m_life[s] = life;
      end
    end else begin
      int b = elect();
      if (b >= 0) m_vld[b] = 0;
    end
    if (twice) begin
      ins_ptr = PTR_W'(ptr + 1);
      step();
    end
    ins_en = 0; take_en = 0;
    sw_req = 0;
    repeat (25) step();
    win(30, 120);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < D; i++) begin
      m_vld[i] = 0; m_ptr[i] = 0; m_cls[i] = 0; m_life[i] = 0;
    end
    repeat (4) @(posedge clk);
    #1;
    rst = 0;
    repeat (20) step();
    check_all("R1");

    do_op(30, 120, 1, 'h100, 0, 100, 0); check_all("R2");
    do_op(30, 120, 1, 'h200, 2, 90, 0);  check_all("R3");
    do_op(30, 120, 1, 'h300, 2, 60, 0);  check_all("R4");
    do_op(30, 120, 1, 'h400, 2, 60, 0);  check_all("R5");
    do_op(30, 120, 0, 0, 0, 0, 0);       check_all("R6");
    do_op(30, 120, 1, 'h500, 1, 6, 0);   check_all("R2");

    // aging: 0x500 climbs to class 3, is elected, then expires
    for (int k = 0; k < 7; k++) begin
      repeat (TK) step();
      win(30, 120);
      check_all("R8 R9 R10");
    end
    chk("R10", "drops", longint'(drop_cnt), 1);

    // operation without a grant is ignored
    win(30, 100);
    ins_en = 1; ins_ptr = 'h777; ins_cls = 3; ins_life = 9;
    repeat (3) step();
    ins_en = 0;
    repeat (25) step();
    check_all("R11");
    // second operation inside one grant is ignored
    do_op(30, 120, 1, 'h600, 1, 150, 1); check_all("R11");

    // insert lands just before a tick; its election pass overlaps the tick
    do_op(TK - 14, TK - 14, 1, 'h700, 3, 100, 0);
    check_all("R13");

    do_op(30, 120, 1, 'h800, 0, 300, 0); check_all("R7");
    do_op(30, 120, 1, 'h900, 1, 310, 0); check_all("R7");
    do_op(30, 120, 1, 'hA00, 0, 320, 0); check_all("R7");
    chk("R7", "full", longint'(full), 1);
    do_op(30, 120, 1, 'hB00, 3, 1, 0);   check_all("R7");

    for (int k = 0; k < D; k++) begin
      do_op(30, 120, 0, 0, 0, 0, 0);
      check_all("R6");
    end
    chk("R12", "empty", longint'(empty), 1);
    do_op(30, 120, 0, 0, 0, 0, 0);       check_all("R12");
    do_op(30, 120, 1, 'hC00, 1, 200, 0); check_all("R12");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule